// File: doc/BRIEF.md
# Two-Master I2C Interrupt, Halt and Reset Controller

This block is the status and recovery logic that sits beside the two I2C masters of a camera-sensor control engine. The queue engines and bus engines report completions and faults as single-cycle pulses on a 32-bit event vector. The block latches those pulses into a sticky status register. A mask register selects which status bits may raise the level interrupt line. Software acknowledges events by writing ones to a clear register. It then writes a global-clear strobe, which drops the interrupt line until a fresh unmasked event arrives.

The block also runs the recovery path. A halt request, from software or from any error event of a master, asks that master's queue engine to stop both of its queues. An acknowledge is issued when the engine reports idle, or when a bounded wait expires. Every halt acknowledge starts a reset of that master's sub-blocks. Every reset, whether software-written or automatic, ends by setting a reset-done status bit.

Top module: `i2c_recov_irq_ctl`

## Requirements
- R1: Every event bit on `evt_i`, except bits 24, 25 and 26, sets the matching status bit at the next clock edge. Those three positions are written only by the block's own reset-done (bit 24), master 0 halt acknowledge (bit 25) and master 1 halt acknowledge (bit 26).
- R2: A clear write (`wr_sel`=1) clears the status bits at the positions where the data has ones. An event arriving in the same cycle as the clear for the same bit leaves that bit set.
- R3: A mask write (`wr_sel`=0) stores the mask. Reading with `rd_sel`=0 returns the mask, `rd_sel`=5 returns the status and any other selector returns zero. `irq_o` can be high only when some status bit with its mask bit set is 1.
- R4: A global-clear write (`wr_sel`=2) drops `irq_o` even while status bits remain set. A later event on a masked-in bit raises it again. An unmasked event in the same cycle as the global clear keeps `irq_o` high.
- R5: A halt write (`wr_sel`=3) with data bit 0 raises `halt_req_o[0]`, and with data bit 1 raises `halt_req_o[1]`. Each request is held until its own acknowledge.
- R6: While `halt_req_o[m]` is high, `q_idle_i[m]` high acknowledges the halt at that clock edge. The acknowledge drops the request and sets status bit 25+m.
- R7: If `q_idle_i[m]` is never seen, the halt is acknowledged at the HALT_LIMIT-th clock edge after the request began.
- R8: An event in master 0's error set (0x18000EE6) or master 1's error set (0x60EE6000) also starts a halt of that master.
- R9: Each halt acknowledge starts a reset of its master. `blk_rst_o` carries 0x000003F1 for master 0 and 0x0003F001 for master 1, for RST_CYCLES cycles. When both acknowledge together, it carries the OR of the two.
- R10: A reset write (`wr_sel`=4) drives `blk_rst_o` with the written mask for RST_CYCLES cycles. At the edge where it ends, `blk_rst_o` returns to zero and status bit 24 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write selector: 0 mask, 1 clear, 2 global clear, 3 halt, 4 reset |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read selector: 0 mask, 5 status |
| rd_data | output | 32 | Read data, combinational |
| evt_i | input | 32 | Event pulses from queue and bus engines |
| q_idle_i | input | 2 | Per-master queue engine idle or aborted |
| halt_req_o | output | 2 | Per-master halt request to the queue engines |
| blk_rst_o | output | 32 | Sub-block reset mask, held for the reset duration |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the collision cases first.

- **Clear and event in the same cycle.** A design that let the clear win would lose a completion.
- **Global clear and event in the same cycle.** A design that let the global clear win would leave an unmasked event with no interrupt.
- **Writes to bits 24 to 26 on the event input.** A design that latched them would forge halt or reset completions.

It then follows the recovery chain from an error pulse through halt, acknowledge and per-master reset to reset-done, and counts cycles at each stage. An off-by-one in the halt wait bound or the reset duration shows up as a request or reset mask that persists or vanishes one sample early. A wrong per-master mask shows up as the wrong `blk_rst_o` value.

// File: rtl/i2c_recov_pkg.sv
package i2c_recov_pkg;
  localparam int NUM_MST = 2;
  localparam int DW      = 32;

  localparam logic [DW-1:0] M0_ERR_SET  = 32'h1800_0EE6;
  localparam logic [DW-1:0] M1_ERR_SET  = 32'h60EE_6000;
  localparam logic [DW-1:0] INTERNAL_BITS = 32'h0700_0000;
  localparam logic [DW-1:0] M0_RST_MASK = 32'h0000_03F1;
  localparam logic [DW-1:0] M1_RST_MASK = 32'h0003_F001;
  localparam int RST_DONE_POS  = 24;
  localparam int HALT_ACK_POS0 = 25;

  typedef enum logic [2:0] {
    SEL_MASK  = 3'd0,
    SEL_CLEAR = 3'd1,
    SEL_GCLR  = 3'd2,
    SEL_HALT  = 3'd3,
    SEL_RESET = 3'd4,
    SEL_STAT  = 3'd5
  } reg_sel_e;

  function automatic logic [DW-1:0] err_set(input int m);
    return (m == 0) ? M0_ERR_SET : M1_ERR_SET;
  endfunction

  function automatic logic [DW-1:0] mst_rst_mask(input int m);
    return (m == 0) ? M0_RST_MASK : M1_RST_MASK;
  endfunction

  // Set beats clear so a same-cycle event survives.
  function automatic logic [DW-1:0] next_status(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] clr,
                                                input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/i2c_recov_irq_status.sv
module i2c_recov_irq_status
  import i2c_recov_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic          gclr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] status_q;
  logic [DW-1:0] mask_q;
  logic          armed_q;
  logic          new_unmasked;

  assign new_unmasked = |(set_i & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      armed_q  <= 1'b1;
    end else begin
      status_q <= next_status(status_q, clr_we ? wdata : '0, set_i);
      if (mask_we) mask_q <= wdata;
      if (new_unmasked)  armed_q <= 1'b1;
      else if (gclr_we)  armed_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = armed_q & |(status_q & mask_q);

  // R4
  gclr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gclr_we && !new_unmasked) |=> !irq_o);

  // R2
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R4
  evt_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_unmasked |=> irq_o);
endmodule

// File: rtl/i2c_recov_halt.sv
module i2c_recov_halt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic idle_i,
  output logic req_o,
  output logic ack_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign ack_o = busy_q & (idle_i | (cnt_q == LAST));
  assign req_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ack_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && start_i) |=> req_o);

  // R6
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && idle_i) |=> !req_o);

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && cnt_q == LAST) |=> !req_o);
endmodule

// File: rtl/i2c_recov_rst_seq.sv
module i2c_recov_rst_seq
  import i2c_recov_pkg::*;
#(
  parameter int CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [DW-1:0] req_mask_i,
  output logic [DW-1:0] rst_o,
  output logic          done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q;
  logic [DW-1:0] mask_q;
  logic [CW-1:0] cnt_q;

  assign done_o = busy_q & (cnt_q == LAST) & !req_i;
  assign rst_o  = busy_q ? mask_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (req_i) begin
      busy_q <= 1'b1;
      mask_q <= (busy_q ? mask_q : '0) | req_mask_i;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      mask_q <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> ((rst_o & $past(req_mask_i)) == $past(req_mask_i)));

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (rst_o == '0));
endmodule

// File: rtl/i2c_recov_irq_ctl.sv
module i2c_recov_irq_ctl
  import i2c_recov_pkg::*;
#(
  parameter int HALT_LIMIT = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic [31:0] evt_i,
  input  logic [1:0]  q_idle_i,
  output logic [1:0]  halt_req_o,
  output logic [31:0] blk_rst_o,
  output logic        irq_o
);
  logic [DW-1:0]      set_vec;
  logic [DW-1:0]      status;
  logic [DW-1:0]      mask;
  logic [DW-1:0]      rr_mask;
  logic [NUM_MST-1:0] halt_ack;
  logic [NUM_MST-1:0] halt_start;
  logic               rst_done;
  logic               sw_rst;
  logic               rr_req;

  function automatic logic wr_is(input logic en, input logic [2:0] sel,
                                 input reg_sel_e want);
    return en && (sel == want);
  endfunction

  assign sw_rst = wr_is(wr_en, wr_sel, SEL_RESET);

  always_comb begin
    set_vec = evt_i & ~INTERNAL_BITS;
    set_vec[RST_DONE_POS] = rst_done;
    for (int m = 0; m < NUM_MST; m++) set_vec[HALT_ACK_POS0 + m] = halt_ack[m];
  end

  always_comb begin
    rr_mask = sw_rst ? wr_data : '0;
    for (int m = 0; m < NUM_MST; m++)
      if (halt_ack[m]) rr_mask = rr_mask | mst_rst_mask(m);
  end
  assign rr_req = sw_rst | (|halt_ack);

  i2c_recov_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (wr_is(wr_en, wr_sel, SEL_MASK)),
    .clr_we   (wr_is(wr_en, wr_sel, SEL_CLEAR)),
    .gclr_we  (wr_is(wr_en, wr_sel, SEL_GCLR)),
    .wdata    (wr_data),
    .set_i    (set_vec),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    assign halt_start[m] = (wr_is(wr_en, wr_sel, SEL_HALT) && wr_data[m])
                         || (|(evt_i & err_set(m)));
    i2c_recov_halt #(.LIMIT(HALT_LIMIT)) u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (halt_start[m]),
      .idle_i  (q_idle_i[m]),
      .req_o   (halt_req_o[m]),
      .ack_o   (halt_ack[m])
    );
  end

  i2c_recov_rst_seq #(.CYCLES(RST_CYCLES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (rr_req),
    .req_mask_i (rr_mask),
    .rst_o      (blk_rst_o),
    .done_o     (rst_done)
  );

  always_comb begin
    case (rd_sel)
      SEL_MASK: rd_data = mask;
      SEL_STAT: rd_data = status;
      default:  rd_data = '0;
    endcase
  end

  // R1
  ack_bit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[HALT_ACK_POS0]) |-> $past(halt_ack[0]));

  // R8
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & M1_ERR_SET)) |=> halt_req_o[1] || $past(halt_ack[1]));

  // R9
  ack_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack[0] |=> ((blk_rst_o & M0_RST_MASK) == M0_RST_MASK));

  // R3
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(status & mask)));
endmodule

// File: tb/i2c_recov_irq_ctl_tb.sv
`timescale 1ns/1ps
module i2c_recov_irq_ctl_tb_top;
  localparam int HL = 8;
  localparam int RC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [31:0] evt_i = '0;
  logic [1:0]  q_idle_i = '0;
  logic [1:0]  halt_req_o;
  logic [31:0] blk_rst_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_recov_irq_ctl #(.HALT_LIMIT(HL), .RST_CYCLES(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .evt_i(evt_i),
    .q_idle_i(q_idle_i), .halt_req_o(halt_req_o), .blk_rst_o(blk_rst_o),
    .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] mask;
    logic [31:0] evt;
    logic [31:0] clr;
    logic [31:0] exp_stat;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b1},
    '{32'h0000_0010, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b0},
    '{32'hFFFF_FFFF, 32'h0011_1111, 32'h0000_0011, 32'h0011_1111, 1'b1},
    '{32'h0010_0000, 32'h0700_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h8000_0000, 32'h8000_9008, 32'h0000_0000, 32'h8000_9008, 1'b1},
    '{32'h0000_1000, 32'h0000_0100, 32'h0000_0000, 32'h0000_0100, 1'b0}
  };

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] rd(input logic [2:0] sel);
    rd_sel = sel;
    return (sel == 3'd0) ? dut_i.rd_data : rd_data;
  endfunction

  task automatic read(input logic [2:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #0.1;
    v = rd_data;
  endtask

  task automatic wipe;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h1);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    read(3'd5, v); check("R1 reset status", v, 32'h0);
    read(3'd0, v); check("R3 reset mask", v, 32'h0);
    check("R4 reset irq", {31'b0, irq_o}, 32'h0);
    check("R5 reset halt_req", {30'b0, halt_req_o}, 32'h0);
    check("R10 reset blk_rst", blk_rst_o, 32'h0);

    // table walk: R1 R2 R3
    for (int i = 0; i < 6; i++) begin
      wipe();
      wr(3'd0, VECS[i].mask);
      read(3'd0, v); check("R3 mask readback", v, VECS[i].mask);
      evt_i = VECS[i].evt;
      if (VECS[i].clr != 0) begin wr_en = 1'b1; wr_sel = 3'd1; wr_data = VECS[i].clr; end
      tick();
      evt_i = '0; wr_en = 1'b0; wr_data = '0;
      read(3'd5, v); check("R1 R2 status after event", v, VECS[i].exp_stat);
      check("R3 irq gating", {31'b0, irq_o}, {31'b0, VECS[i].exp_irq});
      wr(3'd1, VECS[i].exp_stat);
      read(3'd5, v); check("R2 clear by ones", v, 32'h0);
    end
    read(3'd7, v); check("R3 unused selector", v, 32'h0);

    // R4: global clear, re-arm, same-cycle race
    wipe();
    wr(3'd0, 32'h0000_0011);
    evt_i = 32'h1; tick(); evt_i = '0;
    check("R4 irq up", {31'b0, irq_o}, 32'h1);
    wr(3'd2, 32'h1);
    check("R4 irq dropped by global clear", {31'b0, irq_o}, 32'h0);
    read(3'd5, v); check("R4 status kept after global clear", v, 32'h1);
    evt_i = 32'h10; tick(); evt_i = '0;
    check("R4 irq re-armed", {31'b0, irq_o}, 32'h1);
    evt_i = 32'h1; wr(3'd2, 32'h1); evt_i = '0;
    check("R4 event beats same-cycle global clear", {31'b0, irq_o}, 32'h1);

    // R5 R6 R9 R10: software halt master 0, idle after 3 cycles
    wipe();
    wr(3'd3, 32'h1);
    check("R5 halt master 0", {30'b0, halt_req_o}, 32'h1);
    tick(); tick();
    check("R5 halt held", {30'b0, halt_req_o}, 32'h1);
    q_idle_i = 2'b01; tick(); q_idle_i = '0;
    check("R6 halt released", {30'b0, halt_req_o}, 32'h0);
    read(3'd5, v); check("R6 ack bit 25", v, 32'h0200_0000);
    check("R9 master 0 reset mask", blk_rst_o, 32'h0000_03F1);
    repeat (RC - 1) tick();
    check("R9 reset still held", blk_rst_o, 32'h0000_03F1);
    tick();
    check("R10 reset ended", blk_rst_o, 32'h0);
    read(3'd5, v); check("R10 reset-done bit 24", v, 32'h0300_0000);

    // R7: master 1 timeout
    wipe();
    wr(3'd3, 32'h2);
    check("R5 halt master 1", {30'b0, halt_req_o}, 32'h2);
    repeat (HL - 1) tick();
    check("R7 request before limit", {30'b0, halt_req_o}, 32'h2);
    tick();
    check("R7 forced ack drops request", {30'b0, halt_req_o}, 32'h0);
    read(3'd5, v); check("R7 ack bit 26", v, 32'h0400_0000);
    check("R9 master 1 reset mask", blk_rst_o, 32'h0003_F001);
    repeat (RC + 2) tick();

    // R5 R9: both masters halt, ack together
    wipe();
    wr(3'd3, 32'h3);
    check("R5 halt both", {30'b0, halt_req_o}, 32'h3);
    q_idle_i = 2'b11; tick(); q_idle_i = '0;
    check("R9 merged reset mask", blk_rst_o, 32'h0003_F3F1);
    read(3'd5, v); check("R6 both ack bits", v, 32'h0600_0000);
    repeat (RC + 2) tick();

    // R8: error event auto-halts master 1
    wipe();
    evt_i = 32'h0000_2000; tick(); evt_i = '0;
    check("R8 error starts halt", {30'b0, halt_req_o}, 32'h2);
    read(3'd5, v); check("R8 error bit latched", v, 32'h0000_2000);
    q_idle_i = 2'b10; tick(); q_idle_i = '0;
    check("R9 error recovery reset", blk_rst_o, 32'h0003_F001);
    repeat (RC) tick();
    read(3'd5, v); check("R10 recovery done", v, 32'h0500_2000);

    // R10: software full reset
    wipe();
    wr(3'd4, 32'h0F73_F3F7);
    check("R10 full reset mask", blk_rst_o, 32'h0F73_F3F7);
    repeat (RC - 1) tick();
    check("R10 full reset held", blk_rst_o, 32'h0F73_F3F7);
    read(3'd5, v); check("R10 no done yet", v, 32'h0);
    tick();
    check("R10 full reset ended", blk_rst_o, 32'h0);
    read(3'd5, v); check("R10 done bit", v, 32'h0100_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule